// File: doc/BRIEF.md
# Pipeline Timing-Error Recovery Controller

This block steers recovery for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) whose stage registers can flag a late-arriving result. It keeps a valid bit and a program counter for every stage, so it can act as the control shadow of a datapath it does not contain. When a stage flags an error, the controller turns that stage's outgoing slot into a bubble. A flush token then walks backward toward fetch, one stage per cycle, and discards every younger instruction it meets. When the token reaches fetch, fetch is pointed back at the instruction that failed, the same way a mispredicted branch is recovered.

Every signal stays local between neighbouring stages, so no global stall net is needed. The price is a recovery penalty that grows with the depth of the failing stage. The writeback stage is fed from a stabilising register that never reports errors, so only settled values are committed. The memory stage is treated as side-effect free, which means an instruction can be discarded at any point up to and including memory.

Top module: `tr_recovery_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `commit_valid_o`, `bubble_o`, `flush_o` and `restart_valid_o` are all zero, and `fetch_pc_o` equals `RESET_PC`.
- R2: With no errors, fetch advances by `PC_STEP` every cycle. The instruction fetched in cycle n commits in cycle n+4, so `RESET_PC` commits in cycle 4 and `RESET_PC+PC_STEP` in cycle 5.
- R3: An error accepted at stage k (bit k of `stage_err_i`, where bit 0 = fetch, 1 = decode, 2 = execute, 3 = memory) raises `bubble_o[k]` and, when k>0, `bubble_o[k-1]` in that same cycle.
- R4: After an error accepted at stage k>0, `flush_o` is one-hot at bit k-1 in the next cycle and then moves down one bit per cycle until it has left bit 0. It is never wider than one-hot.
- R5: In the cycle the recovery reaches fetch (k cycles after an error at stage k), `restart_valid_o` is high and `restart_pc_o` holds the failing instruction's PC. `fetch_pc_o` equals that PC in the following cycle.
- R6: When several valid stages flag errors in the same cycle, the highest-numbered stage (the oldest instruction) alone sets the bubbles and the restart PC.
- R7: An error at a stage below the flush token's position is ignored. An error at a stage above it replaces the token and the restart PC, and the old token raises no restart.
- R8: Error flags on stages that hold a bubble have no effect on the bubbles, the flush or the restart.
- R9: Under any pattern of errors, the committed PCs are exactly `RESET_PC`, `RESET_PC+PC_STEP`, … in order, with no skip and no repeat.
- R10: Writeback takes no error input. An error at the memory stage keeps its instruction out of writeback, so `commit_valid_o` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_err_i | input | 4 | Timing-error flags, bit 0 fetch … bit 3 memory |
| fetch_pc_o | output | PC_W | PC being fetched this cycle |
| bubble_o | output | 4 | Stage k's outgoing slot is squashed this cycle |
| flush_o | output | 4 | One-hot position of the backward-moving flush token |
| restart_valid_o | output | 1 | Fetch is redirected this cycle |
| restart_pc_o | output | PC_W | PC of the oldest failing instruction |
| commit_valid_o | output | 1 | Writeback commits an instruction this cycle |
| commit_pc_o | output | PC_W | PC of the committing instruction |

## Verification
A corrupted valid bit or token position is visible at the commit port within four cycles, as a skipped, repeated or out-of-order PC. The commit stream is therefore compared with the error-free sequence over long random error runs. A wrong restart PC is visible in `restart_pc_o` in the cycle the token reaches fetch, and in `fetch_pc_o` one cycle later. A wrong priority between simultaneous or overlapping errors shows up as a restart delayed or advanced by a cycle, and directed cases pin down that exact cycle.

// File: rtl/tr_pkg.sv
package tr_pkg;
    // Stage numbering; higher index holds the older instruction.
    typedef enum int {
        STG_FETCH  = 0,
        STG_DECODE = 1,
        STG_EXEC   = 2,
        STG_MEMORY = 3,
        STG_WBACK  = 4
    } stage_e;

    localparam int NUM_STAGES = 5;
    localparam int ERR_STAGES = NUM_STAGES - 1;  // writeback never flags
endpackage

// File: rtl/tr_oldest_pick.sv
module tr_oldest_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Highest set bit wins: it names the oldest instruction.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tr_recovery_ctrl.sv
module tr_recovery_ctrl
    import tr_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = 32'h0000_1000,
    parameter int              PC_STEP  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ERR_STAGES-1:0] stage_err_i,
    output logic [PC_W-1:0]       fetch_pc_o,
    output logic [ERR_STAGES-1:0] bubble_o,
    output logic [ERR_STAGES-1:0] flush_o,
    output logic                  restart_valid_o,
    output logic [PC_W-1:0]       restart_pc_o,
    output logic                  commit_valid_o,
    output logic [PC_W-1:0]       commit_pc_o
);
    localparam int NE   = ERR_STAGES;
    localparam int LAST = NUM_STAGES - 1;
    localparam int IW   = $clog2(NE);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    typedef struct packed {
        logic [PC_W-1:0]           fetch_pc;
        logic [LAST:1]             vld;
        logic [LAST:1][PC_W-1:0]   pc;
        logic [NE-1:0]             flush;
        logic [PC_W-1:0]           rpc;
    } state_t;

    state_t st_d, st_q;

    logic [NE-1:0]           vld_cur;
    logic [NE-1:0][PC_W-1:0] pc_cur;
    logic [NE-1:0]           cand;
    logic                    new_hit;
    logic [IW-1:0]           new_idx;
    logic [NE-1:0]           eff;
    logic [PC_W-1:0]         eff_rpc;
    logic [NE-1:0]           kill;

    // Current occupant of each error-capable stage; fetch always holds a live slot.
    always_comb begin
        vld_cur[0] = 1'b1;
        pc_cur[0]  = st_q.fetch_pc;
        for (int k = 1; k < NE; k++) begin
            vld_cur[k] = st_q.vld[k];
            pc_cur[k]  = st_q.pc[k];
        end
    end

    // An error counts only on a live slot older than any token in flight.
    for (genvar k = 0; k < NE; k++) begin : g_cand
        assign cand[k] = stage_err_i[k] & vld_cur[k] & ~(|st_q.flush[NE-1:k]);
    end

    tr_oldest_pick #(.N(NE)) i_pick (
        .req (cand),
        .hit (new_hit),
        .idx (new_idx)
    );

    // Effective token this cycle: a fresh error replaces the one in flight.
    always_comb begin
        eff     = new_hit ? (NE'(1) << new_idx) : st_q.flush;
        eff_rpc = new_hit ? pc_cur[new_idx] : st_q.rpc;
    end

    // The token squashes its own stage and the one behind it, so that no
    // younger instruction slips past while both move in opposite directions.
    for (genvar k = 0; k < NE; k++) begin : g_kill
        if (k + 1 < NE) begin : g_pair
            assign kill[k] = eff[k] | eff[k+1];
        end else begin : g_top
            assign kill[k] = eff[k];
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.flush = eff >> 1;
        st_d.rpc   = eff_rpc;
        st_d.fetch_pc = eff[0] ? eff_rpc : st_q.fetch_pc + STEP;
        for (int k = 0; k < NE; k++) begin
            st_d.vld[k+1] = vld_cur[k] & ~kill[k];
            st_d.pc[k+1]  = pc_cur[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.fetch_pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_pc_o      = st_q.fetch_pc;
    assign bubble_o        = kill;
    assign flush_o         = st_q.flush;
    assign restart_valid_o = eff[0];
    assign restart_pc_o    = eff_rpc;
    assign commit_valid_o  = st_q.vld[LAST];
    assign commit_pc_o     = st_q.pc[LAST];

    // ---------------- assertions ----------------
    logic            seen_q;
    logic [PC_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (commit_valid_o) begin
            seen_q <= 1'b1;
            last_q <= commit_pc_o;
        end
    end

    assert_flush_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush_o));

    for (genvar k = 1; k < NE; k++) begin : g_walk
        assert_flush_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.flush[k] && !new_hit) |=> flush_o[k-1]);
    end

    assert_refetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid_o |=> (fetch_pc_o == $past(restart_pc_o)));

    assert_mem_bubble_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o[NE-1] |=> !commit_valid_o);

    assert_commit_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid_o && seen_q) |-> (commit_pc_o == last_q + STEP));
endmodule

// File: tb/test_tr_recovery_ctrl.sv
module test_tr_recovery_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 32;
    localparam logic [PC_W-1:0] RST_PC = 32'h0000_1000;
    localparam int STEP = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      err = '0;
    logic [PC_W-1:0] fetch_pc, restart_pc, commit_pc;
    logic [3:0]      bubble, flush;
    logic            restart_valid, commit_valid;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tr_recovery_ctrl #(.PC_W(PC_W), .RESET_PC(RST_PC), .PC_STEP(STEP)) i_tr_recovery_ctrl (
        .clk(clk), .rst_n(rst_n), .stage_err_i(err),
        .fetch_pc_o(fetch_pc), .bubble_o(bubble), .flush_o(flush),
        .restart_valid_o(restart_valid), .restart_pc_o(restart_pc),
        .commit_valid_o(commit_valid), .commit_pc_o(commit_pc)
    );

    function automatic logic [PC_W-1:0] fpc(input int n);
        return RST_PC + PC_W'(n * STEP);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic go(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Leaves the bench at cycle 0: just released, before the first edge.
    task automatic do_reset();
        err = '0;
        rst_n = 1'b0;
        go(3);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [PC_W-1:0] exp_pc;
        int commits;
        void'($urandom(32'd20240611));

        // R1 / R2: reset state and error-free flow
        err = '0;
        #1;
        check("R1 commit in reset", commit_valid, 0);
        do_reset();
        #1;
        check("R1 commit", commit_valid, 0);
        check("R1 bubble", bubble, 0);
        check("R1 flush", flush, 0);
        check("R1 restart", restart_valid, 0);
        check("R1 fetch", fetch_pc, RST_PC);
        go(4); #1;
        check("R2 first commit", commit_valid, 1);
        check("R2 first pc", commit_pc, RST_PC);
        go(1); #1;
        check("R2 second pc", commit_pc, fpc(1));

        // R3 R4 R5 R9: execute-stage error in cycle 6 on fetch(4)
        do_reset();
        go(6); err = 4'b0100; #1;
        check("R3 bubble", bubble, 4'b0110);
        check("R4 no token yet", flush, 0);
        go(1); err = '0; #1;
        check("R4 flush at decode", flush, 4'b0010);
        check("R3 commit older", commit_pc, fpc(3));
        go(1); #1;
        check("R4 flush at fetch", flush, 4'b0001);
        check("R5 restart valid", restart_valid, 1);
        check("R5 restart pc", restart_pc, fpc(4));
        go(1); #1;
        check("R5 refetch", fetch_pc, fpc(4));
        check("R4 flush gone", flush, 0);
        go(2); #1;
        check("R9 gap", commit_valid, 0);
        go(2); #1;
        check("R9 recommit valid", commit_valid, 1);
        check("R9 recommit pc", commit_pc, fpc(4));

        // R10: memory-stage error on fetch(3)
        do_reset();
        go(6); err = 4'b1000; #1;
        check("R10 bubble", bubble, 4'b1100);
        go(1); err = '0; #1;
        check("R10 no commit", commit_valid, 0);
        go(2); #1;
        check("R10 restart pc", restart_pc, fpc(3));

        // R6: decode and memory together; memory wins
        do_reset();
        go(6); err = 4'b1010; #1;
        check("R6 bubble", bubble, 4'b1100);
        go(1); err = '0; #1;
        check("R6 flush", flush, 4'b0100);
        go(2); #1;
        check("R6 restart valid", restart_valid, 1);
        check("R6 restart pc", restart_pc, fpc(3));

        // R7 override: decode error, then older memory error a cycle later
        do_reset();
        go(6); err = 4'b0010; #1;
        check("R7 first bubble", bubble, 4'b0011);
        go(1); err = 4'b1000; #1;
        check("R7 override bubble", bubble, 4'b1100);
        check("R7 old token silent", restart_valid, 0);
        go(1); err = '0; #1;
        check("R7 new token", flush, 4'b0100);
        go(2); #1;
        check("R7 override restart", restart_valid, 1);
        check("R7 override pc", restart_pc, fpc(4));

        // R7 ignore: younger fetch error behind the token
        do_reset();
        go(6); err = 4'b1000; #1;
        go(1); err = 4'b0001; #1;
        check("R7 ignore bubble", bubble, 4'b0110);
        go(1); err = '0; #1;
        check("R7 ignore flush", flush, 4'b0010);
        go(1); #1;
        check("R7 ignore restart pc", restart_pc, fpc(3));
        check("R7 ignore restart", restart_valid, 1);

        // R8: errors on bubbled slots
        do_reset();
        go(6); err = 4'b0100; #1;
        go(1); err = 4'b1100; #1;
        check("R8 bubble", bubble, 4'b0011);
        go(1); err = '0; #1;
        check("R8 restart", restart_valid, 1);
        check("R8 restart pc", restart_pc, fpc(4));

        // R9: random error storm, commit stream must match error-free order
        do_reset();
        exp_pc = RST_PC;
        commits = 0;
        for (int c = 0; c < 4000; c++) begin
            go(1);
            for (int b = 0; b < 4; b++) err[b] = ($urandom % 8) == 0;
            #1;
            if (commit_valid) begin
                check("R9 commit order", commit_pc, exp_pc);
                exp_pc = exp_pc + PC_W'(STEP);
                commits++;
            end
        end
        err = '0;
        check("R9 progress", commits > 400, 1);
        summary();
    end
endmodule